// File: doc/BRIEF.md
# Key Wakeup Edge Interrupt Controller

This block watches a group of asynchronous input pins, eight by default, and turns chosen transitions on them into latched flags. Each channel has its own enable bit and its own edge-polarity bit. When an enabled channel sees a transition of the selected direction, its flag is set and stays set until software clears it. Several flags may be pending at once. All channels share one active-high interrupt request. Software reads the flag register to find out which channels fired.

Software reaches the block through a simple register port. There is a write strobe, a two-bit register select, write data, and a combinational read path driven by a separate read select. Flags are cleared by writing ones to the flag register. The usual sequence is to clear any stale flags, set the polarities, and then turn on the enables.

Top module: `kwu_edge_irq`

## Requirements
- R1: After reset the enable, polarity and flag registers read as zero and `irq` is low.
- R2: A write with `wr_sel`=0 loads the enable register, and a write with `wr_sel`=1 loads the polarity register. Reading with `rd_sel` at the same code returns the stored value.
- R3: A polarity bit of 0 selects falling edges and 1 selects rising edges for that channel. A transition in the other direction leaves the flag unchanged.
- R4: A pin change is synchronized and then detected. The flag reads 1 after the third rising clock edge that follows the pin change, and still reads 0 after the second.
- R5: Edges on several enabled channels in the same cycle set all of their flags together.
- R6: A write with `wr_sel`=2 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R7: When a detected edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: A channel whose enable bit is 0 never sets its flag, whatever the pin does.
- R9: `irq` is high exactly when some channel has both its flag and its enable set. Clearing an enable drops that channel's contribution to `irq` and leaves its flag intact.
- R10: A write with `wr_sel`=3 changes no register. A read with `rd_sel`=3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | WIDTH | Asynchronous channel inputs |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 enable, 1 polarity, 2 flag clear |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 2 | Read source: 0 enable, 1 polarity, 2 flags, 3 zero |
| rd_data | output | WIDTH | Read data, combinational from rd_sel |
| irq | output | 1 | Shared interrupt request |

## Verification
A wrong synchronizer depth or a wrong edge register shows up as a flag that appears one cycle early or late. It can also show up as a flag on the wrong direction of transition. Either case is visible at the flag read three edges after a pin change. A corrupted flag or a wrong merge of set and clear appears on the next read of the flag register after the write cycle. A wrong interrupt combination changes `irq` in the same cycle as the register that feeds it.

// File: rtl/kwu_edge_irq.sv
module kwu_edge_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq
);
  localparam logic [1:0] SEL_EN  = 2'd0;
  localparam logic [1:0] SEL_POL = 2'd1;
  localparam logic [1:0] SEL_FLG = 2'd2;

  logic [WIDTH-1:0] meta_q, sync_q, last_q;
  logic [WIDTH-1:0] en_q, pol_q, flag_q;
  logic [WIDTH-1:0] rise, fall, hit, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;
  assign fall = ~sync_q & last_q;
  assign hit  = en_q & ((pol_q & rise) | (~pol_q & fall));
  assign clr  = (wr_en && wr_sel == SEL_FLG) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_EN)  en_q  <= wr_data;
      if (wr_en && wr_sel == SEL_POL) pol_q <= wr_data;
      flag_q <= (flag_q & ~clr) | hit;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_EN:  rd_data = en_q;
      SEL_POL: rd_data = pol_q;
      SEL_FLG: rd_data = flag_q;
      default: rd_data = '0;
    endcase
  end

  assign irq = |(flag_q & en_q);
endmodule

// File: rtl/kwu_edge_irq_chk.sv
module kwu_edge_irq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] en,
  input logic [WIDTH-1:0] pol,
  input logic [WIDTH-1:0] flags,
  input logic             irq
);
  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd0) |=> $stable(en));

  a_r10_polarity_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd1) |=> $stable(pol));

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    a_r6_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(wr_en && wr_sel == 2'd2 && wr_data[i]));

    a_r8_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(en[i]));
  end
endmodule

bind kwu_edge_irq kwu_edge_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .en(en_q), .pol(pol_q), .flags(flag_q), .irq(irq)
);

// File: tb/kwu_edge_irq_test.sv
module kwu_edge_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;

  kwu_edge_irq #(.WIDTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, input string req, input logic [7:0] exp);
    rd_sel = sel;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pins_to(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd(2'd0, "R1", 8'h00);
    rd(2'd1, "R1", 8'h00);
    rd(2'd2, "R1", 8'h00);
    check("R1", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    wr(2'd0, 8'hA5);
    rd(2'd0, "R2", 8'hA5);
    wr(2'd1, 8'h3C);
    rd(2'd1, "R2", 8'h3C);
    wr(2'd3, 8'hFF);
    rd(2'd0, "R10", 8'hA5);
    rd(2'd1, "R10", 8'h3C);
    rd(2'd3, "R10", 8'h00);
  endtask

  task automatic t_latency_rising;
    @(negedge clk);
    pin_in = 8'h01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(2'd2, "R4", 8'h00);
    @(posedge clk);
    @(negedge clk);
    rd(2'd2, "R4", 8'h01);
    check("R3", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h01);
    rd(2'd2, "R6", 8'h00);
  endtask

  task automatic t_falling;
    pins_to(8'h11);
    rd(2'd2, "R3", 8'h00);
    pins_to(8'h01);
    rd(2'd2, "R3", 8'h10);
    wr(2'd2, 8'hFF);
  endtask

  task automatic t_multi_clear;
    pins_to(8'h07);
    rd(2'd2, "R5", 8'h06);
    wr(2'd2, 8'h02);
    rd(2'd2, "R6", 8'h04);
    wr(2'd2, 8'h00);
    rd(2'd2, "R6", 8'h04);
    wr(2'd2, 8'h04);
  endtask

  task automatic t_disabled;
    wr(2'd0, 8'hFE);
    pins_to(8'h06);
    pins_to(8'h07);
    rd(2'd2, "R8", 8'h00);
    check("R8", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_mask;
    pins_to(8'h0F);
    rd(2'd2, "R9", 8'h08);
    check("R9", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'hF7);
    check("R9", {7'd0, irq}, 8'h00);
    rd(2'd2, "R9", 8'h08);
    wr(2'd0, 8'hFF);
    check("R9", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_set_wins;
    pins_to(8'h0B);
    rd(2'd2, "R7", 8'h00);
    @(negedge clk);
    pin_in = 8'h0F;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h04;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd2, "R7", 8'h04);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'hFF);
    t_latency_rising;
    t_falling;
    t_multi_clear;
    t_disabled;
    t_mask;
    t_set_wins;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule